// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block turns a single-wire, pulse-width-coded line into a stream of bits. The line idles high. Every bit slot begins when the line falls. A short low pulse encodes a zero and a long low pulse encodes a one. The decoder passes the raw line through a two-flop synchroniser and treats each falling edge as the start of a slot. It then counts reference ticks and looks at the line once, at a fixed delay chosen inside the window where a short pulse has already ended and a long pulse is still low. The recovered bit appears with a one-cycle valid strobe.

All timing is counted in ticks of the `tick` enable, so the same logic serves any reference rate. With the default values and a 16 kHz tick, the sample point is about 1.9 ms after the slot start, the shortest legal slot is 5 ms, the longest legal low level is 6 ms, and the high recovery before a new edge must last at least 0.5 ms. A separate one-cycle error strobe reports three kinds of timing fault: a slot that ends too early, a recovery gap that is too short, and a line held low for too long. Grouping bits into frames is left to the logic downstream.

Top module: `pw_bit_decoder`

## Requirements
- R1: After reset, `bit_valid` and `err` are 0, and the first falling edge seen is never judged for timing.
- R2: A falling edge of `line_in` is taken as a slot start two clocks after the synchroniser captures it. `bit_valid` pulses exactly `SAMPLE_TICKS` ticks after the clock edge that registers the start. When `tick` is held high, a low level first driven before clock edge D+1 gives a strobe visible after edge D+3+`SAMPLE_TICKS`.
- R3: `bit_out` is 1 when the synchronised line is still low at the sample point and 0 when it is high. When `tick` is held high, a low pulse spanning L clock edges reads as 1 exactly when L ≥ `SAMPLE_TICKS`+1.
- R4: `bit_valid` lasts one cycle and occurs at most once per slot.
- R5: A slot start that follows the previous start by fewer than `MIN_SLOT_TICKS` ticks raises `err` for one cycle. The edge is still accepted as a new slot start, and its bit is sampled normally.
- R6: A falling edge that follows fewer than `MIN_HIGH_TICKS` ticks of high line raises `err`. A gap of exactly `MIN_HIGH_TICKS` ticks does not.
- R7: A low level that lasts `MAX_LOW_TICKS` ticks raises `err` once. With `tick` held high, this happens `MAX_LOW_TICKS`+2 cycles after the driving negedge. A low of `MAX_LOW_TICKS`-1 ticks raises nothing.
- R8: After a stuck-low error, the next falling edge starts a slot without being judged for slot length or gap.
- R9: When a falling edge lands on the cycle in which the previous slot would reach its sample point, the edge wins. The old slot yields no bit, and the early-slot error is raised.
- R10: Counters advance only on cycles with `tick` high, so all limits scale with the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the reference rate |
| line_in | input | 1 | Raw pulse-width-coded line, idle high |
| bit_out | output | 1 | Recovered bit, held until the next sample |
| bit_valid | output | 1 | One-cycle strobe, `bit_out` is new |
| err | output | 1 | One-cycle timing-fault strobe |

## Verification
Two functions can fall in the same cycle: the sampling of the current slot and the start of a new slot. The bench provokes this by placing a falling edge exactly `SAMPLE_TICKS` ticks after the previous start. It then confirms that no `bit_valid` appears in that cycle, that `err` rises in that very cycle, and that the new slot still delivers its own bit a full sample delay later. The other timing boundaries are swept on both sides by arithmetic on the edge cycles: the sample threshold, the minimum slot length, the minimum gap and the maximum low time.

// File: rtl/pw_bit_decoder.sv
module pw_bit_decoder #(
  parameter int SAMPLE_TICKS   = 30,
  parameter int MIN_SLOT_TICKS = 80,
  parameter int MAX_LOW_TICKS  = 96,
  parameter int MIN_HIGH_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic bit_out,
  output logic bit_valid,
  output logic err
);
  localparam int CW = $clog2(MAX_LOW_TICKS + 1) + 1;
  localparam logic [CW-1:0] SLOT_CAP = CW'(MIN_SLOT_TICKS);
  localparam logic [CW-1:0] LOW_CAP  = CW'(MAX_LOW_TICKS);
  localparam logic [CW-1:0] HIGH_CAP = CW'(MIN_HIGH_TICKS);

  logic s1, s2, s3;
  logic armed, started;
  logic [CW-1:0] cnt, lcnt, hcnt;

  wire fall      = s3 & ~s2;
  wire early     = started && (cnt < CW'(MIN_SLOT_TICKS - 1));
  wire gap_short = started && (hcnt < HIGH_CAP);
  wire stuck     = tick && !s2 && (lcnt == CW'(MAX_LOW_TICKS - 1));
  wire sample    = tick && armed && !fall && (cnt == CW'(SAMPLE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      started <= 1'b0;
    end else if (fall) begin
      cnt     <= '0;
      armed   <= 1'b1;
      started <= 1'b1;
    end else begin
      if (tick && cnt != SLOT_CAP) cnt <= cnt + 1'b1;
      if (sample) armed <= 1'b0;
      if (stuck) started <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= '0;
      hcnt <= '0;
    end else begin
      if (s2) lcnt <= '0;
      else if (tick && lcnt != LOW_CAP) lcnt <= lcnt + 1'b1;
      if (!s2) hcnt <= '0;
      else if (tick && hcnt != HIGH_CAP) hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      bit_valid <= sample;
      if (sample) bit_out <= ~s2;
      err <= (fall && (early || gap_short)) || stuck;
    end
  end

  assert_valid_at_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> cnt == CW'(SAMPLE_TICKS));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_early_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && early) |=> err);

  assert_err_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !s2) |=> !err);

  assert_unjudged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !started) |=> !err);
endmodule

// File: tb/pw_bit_decoder_bench.sv
module pw_bit_decoder_bench;
  localparam int SMP = 6, SLOT = 16, MAXL = 20, HMIN = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, line_in = 1'b1;
  logic bit_out, bit_valid, err;
  logic tick_div = 1'b0;
  int cyc = 0, total = 0, fails = 0, nv = 0, ne = 0;
  int vcyc [0:63];
  int vbit [0:63];
  int ecyc [0:63];
  bit done = 1'b0;

  pw_bit_decoder #(.SAMPLE_TICKS(SMP), .MIN_SLOT_TICKS(SLOT),
                   .MAX_LOW_TICKS(MAXL), .MIN_HIGH_TICKS(HMIN)) u_pw_bit_decoder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .bit_out(bit_out), .bit_valid(bit_valid), .err(err));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick = tick_div ? ((cyc % 3) == 0) : 1'b1;
    if (bit_valid && nv < 64) begin vcyc[nv] = cyc; vbit[nv] = bit_out; nv = nv + 1; end
    if (err && ne < 64) begin ecyc[ne] = cyc; ne = ne + 1; end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(input int l, input int p, output int d);
    line_in = 1'b0;
    d = cyc;
    repeat (l) @(negedge clk);
    line_in = 1'b1;
    repeat (p - l) @(negedge clk);
  endtask

  task automatic idle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int d [0:3];
    int v0, e0;
    int lens [0:3];
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", bit_valid, 0);
    chk("R1 err after reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R1: sweep low lengths around the sample threshold
    lens = '{2, 12, SMP, SMP + 1};
    v0 = nv; e0 = ne;
    for (int i = 0; i < 4; i++) slot(lens[i], 20, d[i]);
    idle();
    chk("R4 valid count", nv - v0, 4);
    chk("R1 first edge unjudged", ne - e0, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R2 valid cycle", vcyc[v0 + i], d[i] + 3 + SMP);
      chk("R3 bit value", vbit[v0 + i], (lens[i] >= SMP + 1) ? 1 : 0);
    end

    // R5: period SLOT-1 flagged, SLOT accepted
    v0 = nv; e0 = ne;
    slot(2, 20, d[0]); slot(2, SLOT - 1, d[1]); slot(2, SLOT, d[2]); slot(2, 20, d[3]);
    idle();
    chk("R5 err count", ne - e0, 1);
    chk("R5 err cycle", ecyc[e0], d[2] + 3);
    chk("R5 new slot still sampled", nv - v0, 4);

    // R6: gap of HMIN ok, HMIN-1 flagged
    v0 = nv; e0 = ne;
    slot(2, 20, d[0]); slot(20 - HMIN, 20, d[1]); slot(21 - HMIN, 20, d[2]); slot(2, 20, d[3]);
    idle();
    chk("R6 err count", ne - e0, 1);
    chk("R6 err cycle", ecyc[e0], d[3] + 3);

    // R7 R8: stuck low, then an unjudged edge after a 1-cycle gap
    v0 = nv; e0 = ne;
    slot(MAXL - 1, 40, d[0]); slot(MAXL, MAXL + 1, d[1]); slot(2, 20, d[2]);
    idle();
    chk("R7 err count", ne - e0, 1);
    chk("R7 err cycle", ecyc[e0], d[1] + 2 + MAXL);
    chk("R8 valid count", nv - v0, 3);
    chk("R8 bit a", vbit[v0], 1);
    chk("R8 bit b", vbit[v0 + 1], 1);
    chk("R8 bit c", vbit[v0 + 2], 0);

    // R9: edge on the sample cycle
    v0 = nv; e0 = ne;
    slot(2, 20, d[0]); slot(2, SMP, d[1]); slot(2, 20, d[2]);
    idle();
    chk("R9 valid count", nv - v0, 2);
    chk("R9 err count", ne - e0, 1);
    chk("R9 err cycle", ecyc[e0], d[2] + 3);
    chk("R9 no valid at collision", (vcyc[v0 + 1] == d[2] + 3) ? 1 : 0, 0);
    chk("R9 new slot valid cycle", vcyc[v0 + 1], d[2] + 3 + SMP);

    // R10: one tick every three cycles
    tick_div = 1'b1;
    idle();
    v0 = nv; e0 = ne;
    lens = '{4, 30, 4, 4};
    slot(4, 60, d[0]); slot(30, 60, d[1]); slot(4, 39, d[2]); slot(4, 60, d[3]);
    idle();
    chk("R10 valid count", nv - v0, 4);
    for (int i = 0; i < 4; i++) chk("R10 bit value", vbit[v0 + i], (lens[i] == 30) ? 1 : 0);
    chk("R10 err count", ne - e0, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule